// File: doc/BRIEF.md
# Cache range maintenance sequencer

The sequencer takes one maintenance request at a time from a host. A request names an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. The sequencer turns it into an ordered stream of commands for a downstream second-level cache controller. A command is either a single-line clean-and-invalidate, or a range command sent as two writes: the range start, then the inclusive range end.

Each range command covers only whole lines. It is capped at a fixed number of bytes and never crosses a page boundary. For an invalidate, partial lines at either edge are cleaned and invalidated one line at a time, so that no neighbouring data is discarded. When the write-through override input is set, the cache cannot hold dirty data, so clean work is skipped. Each command is held until the controller acknowledges it. A one-cycle done pulse marks the end of the request.

Top module: `l2_range_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid` and `done` are 0.
- R2: For an invalidate (`req_op`=0) whose start is not line-aligned, the first command is a line clean-and-invalidate (`cmd_kind`=3'b001, `cmd_clean`=1) at the start address rounded down to a line. Range work then begins at the next line boundary.
- R3: For an invalidate whose end is not line-aligned, a line clean-and-invalidate is issued at the end address rounded down to a line. It comes after any head line command. It is skipped when that line is the one already handled by the head command. Range work then stops at that line boundary.
- R4: For a clean (`req_op`=1) or a flush (`req_op`=2), the range begins at the start rounded down to a line and ends at the end rounded up to a line.
- R5: Each range chunk starts where the previous chunk ended. It ends at the smallest of: its start plus MAX_BYTES, the range end, or the next page boundary.
- R6: No range command crosses a page boundary of PAGE_BYTES.
- R7: The range-end write carries the chunk end minus LINE_BYTES. This is the base address of the last line in the chunk.
- R8: `cmd_kind` is one-hot: bit 0 is a line command, bit 1 is a range-start write, bit 2 is a range-end write. `cmd_clean`=1 marks the clean class and line commands; 0 marks the invalidate class. Every acknowledged range-start write is followed directly by the range-end write of the same class.
- R9: A clean with `wt_override`=1 issues no commands, and a request whose end is not above its start issues no commands.
- R10: For a flush, each chunk issues a clean range pair and then an invalidate range pair over the same bounds. With `wt_override`=1, only the invalidate pair is issued.
- R11: A command stays valid and unchanged until the cycle in which `cmd_ack` is sampled high.
- R12: `done` is high for exactly one cycle. It comes in the cycle after the last acknowledge, or in the cycle after acceptance when there is no work. `req_ready` is 0 from acceptance until after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no operation |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| wt_override | input | 1 | Cache is write-through; skip clean work |
| cmd_valid | output | 1 | Downstream command present |
| cmd_kind | output | 3 | One-hot command type |
| cmd_clean | output | 1 | Clean class (1) or invalidate class (0) |
| cmd_addr | output | AW | Line, range-start or inclusive range-end address |
| cmd_ack | input | 1 | Controller accepts the current command |
| done | output | 1 | Request finished (one cycle) |

## Verification
A request accepted on one edge shows its first command, or `done` when there is no work, one cycle later. Each command's successor, or `done`, appears one cycle after the edge at which `cmd_ack` is sampled. The bench drives all inputs on falling edges. It reads every output on the falling edge that follows the edge where the change is due, so each result is compared one register stage after its cause. Acknowledges follow an irregular pattern, so the bench also sees held commands and can check that they stay stable.

// File: rtl/l2_range_seq.sv
module l2_range_seq #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  input  logic          wt_override,
  output logic          cmd_valid,
  output logic [2:0]    cmd_kind,
  output logic          cmd_clean,
  output logic [AW-1:0] cmd_addr,
  input  logic          cmd_ack,
  output logic          done
);
  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] LINE  = AW'(LINE_BYTES);
  localparam logic [AW-1:0] LMASK = ~(LINE - 1'b1);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);
  localparam logic [1:0] OP_INV = 2'd0, OP_CLN = 2'd1, OP_FLU = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_HEAD, S_TAIL, S_RS, S_RE, S_DONE} st_t;
  st_t state;

  logic [1:0]    op_q;
  logic          wt_q, has_rng, tail_pend, cls_clean, first_cls;
  logic [AW-1:0] cur, lim, head_addr, tail_addr;

  logic [AW-1:0] s_dn, e_dn, s_up, e_up, lo_n, hi_n;
  logic          s_off, e_off, empty, head_n, tail_n, rng_n, first_n;

  assign s_dn  = req_start & LMASK;
  assign e_dn  = req_end & LMASK;
  assign s_off = |req_start[LB-1:0];
  assign e_off = |req_end[LB-1:0];
  assign s_up  = s_off ? s_dn + LINE : s_dn;
  assign e_up  = e_off ? e_dn + LINE : e_dn;
  assign empty = (req_end <= req_start) || (req_op == 2'd3);

  always_comb begin
    head_n = 1'b0;
    tail_n = 1'b0;
    lo_n   = s_dn;
    hi_n   = e_up;
    if (req_op == OP_INV) begin
      head_n = !empty && s_off;
      tail_n = !empty && e_off && !(s_off && (e_dn == s_dn));
      lo_n   = s_up;
      hi_n   = e_dn;
    end
    rng_n   = !empty && (lo_n < hi_n) && !(req_op == OP_CLN && wt_override);
    first_n = (req_op == OP_CLN) || (req_op == OP_FLU && !wt_override);
  end

  logic [AW:0]   cap_x, pg_x, lim_x, ce_x;
  logic [AW-1:0] ce, rng_last;
  logic          last_chunk;

  always_comb begin
    cap_x = {1'b0, cur} + (AW+1)'(MAX_BYTES);
    pg_x  = {1'b0, cur | PMASK} + 1'b1;
    lim_x = {1'b0, lim};
    ce_x  = cap_x;
    if (pg_x < ce_x)  ce_x = pg_x;
    if (lim_x < ce_x) ce_x = lim_x;
  end
  assign ce         = ce_x[AW-1:0];
  assign last_chunk = (ce_x == lim_x);
  assign rng_last   = ce - LINE;

  logic step;
  assign step = cmd_valid && cmd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= 2'd0;
      wt_q      <= 1'b0;
      has_rng   <= 1'b0;
      tail_pend <= 1'b0;
      cls_clean <= 1'b0;
      first_cls <= 1'b0;
      cur       <= '0;
      lim       <= '0;
      head_addr <= '0;
      tail_addr <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_q      <= req_op;
          wt_q      <= wt_override;
          has_rng   <= rng_n;
          tail_pend <= tail_n;
          cls_clean <= first_n;
          first_cls <= first_n;
          cur       <= lo_n;
          lim       <= hi_n;
          head_addr <= s_dn;
          tail_addr <= e_dn;
          if (head_n)      state <= S_HEAD;
          else if (tail_n) state <= S_TAIL;
          else if (rng_n)  state <= S_RS;
          else             state <= S_DONE;
        end
        S_HEAD: if (step) begin
          if (tail_pend)    state <= S_TAIL;
          else if (has_rng) state <= S_RS;
          else              state <= S_DONE;
        end
        S_TAIL: if (step) state <= has_rng ? S_RS : S_DONE;
        S_RS:   if (step) state <= S_RE;
        S_RE: if (step) begin
          if (op_q == OP_FLU && cls_clean) begin
            cls_clean <= 1'b0;
            state     <= S_RS;
          end else begin
            cur       <= ce;
            cls_clean <= first_cls;
            state     <= last_chunk ? S_DONE : S_RS;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign cmd_valid = (state == S_HEAD) || (state == S_TAIL) || (state == S_RS) || (state == S_RE);
  assign cmd_kind  = (state == S_RS) ? 3'b010 : (state == S_RE) ? 3'b100 :
                     cmd_valid ? 3'b001 : 3'b000;
  assign cmd_clean = (state == S_HEAD) || (state == S_TAIL) ||
                     (((state == S_RS) || (state == S_RE)) && cls_clean);
  assign cmd_addr  = (state == S_HEAD) ? head_addr : (state == S_TAIL) ? tail_addr :
                     (state == S_RS) ? cur : (state == S_RE) ? rng_last : '0;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_kind) && $stable(cmd_clean)); // R11
  AST_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $countones(cmd_kind) == 1); // R8
  AST_RANGE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ack && cmd_kind[1] |=> cmd_valid && cmd_kind[2] && cmd_clean == $past(cmd_clean)); // R8
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[2] |-> cmd_addr[AW-1:PB] == cur[AW-1:PB]); // R6
  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind[2] |-> (cmd_addr - cur) < AW'(MAX_BYTES)); // R5
  AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt_q && op_q != OP_INV |-> !cmd_clean && op_q == OP_FLU); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R12
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !req_ready); // R12
endmodule

// File: tb/sim_l2_range_seq.sv
module sim_l2_range_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LINE = 32, MAXB = 128, PAGE = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, wt_override = 1'b0, cmd_valid, cmd_clean, cmd_ack = 1'b0, done;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_start = '0, req_end = '0, cmd_addr;
  logic [2:0] cmd_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_range_seq #(.AW(AW), .LINE_BYTES(LINE), .MAX_BYTES(MAXB), .PAGE_BYTES(PAGE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .wt_override(wt_override), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_clean(cmd_clean), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack), .done(done));

  int checks = 0, errors = 0, ackpat = 0;
  logic [2:0] ek [64];
  logic       ec [64];
  logic [31:0] ea [64];
  int ne;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add(input logic [2:0] k, input logic c, input logic [31:0] a);
    ek[ne] = k; ec[ne] = c; ea[ne] = a; ne++;
  endtask

  task automatic build(input int op, input int s, input int e, input bit wt);
    int lo, hi, ce;
    ne = 0;
    if (e <= s || op == 3) return;
    if (op == 0) begin
      if (s % LINE != 0) add(3'b001, 1'b1, 32'(s - s % LINE));
      if (e % LINE != 0 && !(s % LINE != 0 && e / LINE == s / LINE)) add(3'b001, 1'b1, 32'(e - e % LINE));
      lo = ((s + LINE - 1) / LINE) * LINE;
      hi = (e / LINE) * LINE;
    end else begin
      if (op == 1 && wt) return;
      lo = (s / LINE) * LINE;
      hi = ((e + LINE - 1) / LINE) * LINE;
    end
    while (lo < hi) begin
      ce = lo + MAXB;
      if (hi < ce) ce = hi;
      if ((lo / PAGE + 1) * PAGE < ce) ce = (lo / PAGE + 1) * PAGE;
      if (op == 1 || (op == 2 && !wt)) begin add(3'b010, 1'b1, 32'(lo)); add(3'b100, 1'b1, 32'(ce - LINE)); end
      if (op != 1) begin add(3'b010, 1'b0, 32'(lo)); add(3'b100, 1'b0, 32'(ce - LINE)); end
      lo = ce;
    end
  endtask

  function automatic string tag_of(input int i, input int op);
    if (ek[i] == 3'b001) return (i == 0 && op == 0 && ea[i][4:0] == 0 && ne > 0) ? "R2" : "R3";
    if (ek[i] == 3'b010) return (op == 0) ? "R2" : (op == 2 ? "R10" : "R4");
    return (i + 1 == ne) ? "R7" : "R5";
  endfunction

  task automatic run(input int op, input int s, input int e, input bit wt);
    int got = 0;
    bit last_ev = 1'b1, pv = 1'b0, pa = 1'b0, fin = 1'b0;
    logic [2:0] pk = '0; logic pc = 1'b0; logic [31:0] pad = '0;
    build(op, s, e, wt);
    req_op = 2'(op); req_start = 32'(s); req_end = 32'(e); wt_override = wt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
      if (done) begin
        chk(last_ev, "R12 done timing", 64'(last_ev), 64'd1);
        chk(got == ne, (op == 1 && wt) ? "R9 count" : "R6 count", 64'(got), 64'(ne));
        fin = 1'b1;
      end else begin
        chk(!req_ready, "R12 busy ready", 64'(req_ready), 64'd0);
        if (cmd_valid) begin
          if (pv && !pa) chk(cmd_kind == pk && cmd_clean == pc && cmd_addr == pad, "R11 hold",
                             {cmd_kind, cmd_clean, cmd_addr}, {pk, pc, pad});
          ackpat++;
          cmd_ack = (ackpat % 5 != 1) && (ackpat % 7 != 3);
          if (cmd_ack) begin
            if (got < ne) begin
              chk(cmd_kind == ek[got] && cmd_clean == ec[got] && cmd_addr == ea[got],
                  (cmd_clean != ec[got]) ? "R10" : tag_of(got, op),
                  {cmd_kind, cmd_clean, cmd_addr}, {ek[got], ec[got], ea[got]});
              chk(cmd_kind == 3'b001 || cmd_addr[31:8] == ea[got][31:8], "R6 page", cmd_addr, ea[got]);
            end else chk(1'b0, "R9 extra cmd", cmd_addr, 64'd0);
            got++;
          end
          pv = 1'b1; pa = cmd_ack; pk = cmd_kind; pc = cmd_clean; pad = cmd_addr;
          last_ev = cmd_ack;
        end else begin
          cmd_ack = 1'b0; pv = 1'b0; last_ev = 1'b0;
        end
        @(negedge clk);
        cmd_ack = 1'b0;
      end
    end
    if (!fin) chk(1'b0, "R12 no done", 64'd0, 64'd1);
    @(negedge clk);
    chk(!done && req_ready, "R12 single pulse", {done, req_ready}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1 reset", {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1 after reset", {req_ready, cmd_valid, done}, 3'b100);
    // directed corners
    run(0, 32'h1021, 32'h1025, 1'b0);   // R3 same partial line
    run(0, 32'h1040, 32'h1040, 1'b0);   // R9 empty
    run(1, 32'h1000, 32'h1400, 1'b1);   // R9 wt clean
    run(2, 32'h10E0, 32'h1220, 1'b0);   // R10 page crossing
    run(2, 32'h10E0, 32'h1220, 1'b1);   // R10 wt
    run(1, 32'h1007, 32'h1101, 1'b0);   // R4 rounding
    run(0, 32'h1007, 32'h1301, 1'b0);   // R2 R3 edges
    run(3, 32'h1000, 32'h1100, 1'b0);
    for (int op = 0; op < 3; op++)
      for (int wt = 0; wt < 2; wt++)
        for (int s = 5; s < 620; s += 29)
          for (int e = s - 5; e < s + 430; e += 43)
            run(op, 32'h1000 + s, 32'h1000 + e, wt[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule